// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block is a parameterised set-associative data cache placed between a CPU-side request port and a main-memory port. A CPU request carries a byte address, a read/write flag, write data and byte strobes. The request is held until a one-cycle `cpu_ready` pulse. The memory port carries one word per valid/ready handshake. Whole lines move as ascending bursts of words. The byte address is split into three fields: a word offset, a set index and a tag. The tags of every way in the selected set are compared in parallel.

The write policy is a parameter: write-back, or write-through. The allocation policy is also a parameter: write-allocate, or read-allocate. An external replacement block supplies the victim way on `victim_way`. The controller samples this input on a miss.

The controller has six states: `S_IDLE`, `S_LOOKUP`, `S_WRBACK`, `S_REFILL`, `S_MEMWR` and `S_RESPOND`. Its transitions are:
- IDLE to LOOKUP when a request is accepted.
- LOOKUP to RESPOND on a read hit, and on a write hit in write-back mode.
- LOOKUP to MEMWR on a write hit in write-through mode, and on a write miss under read-allocate.
- LOOKUP to WRBACK on any other miss whose victim is valid and dirty.
- LOOKUP to REFILL on any other miss whose victim is clean or invalid.
- WRBACK to REFILL after the last word of the victim line is written.
- REFILL to LOOKUP after the last word is fetched. The repeated lookup then hits and finishes the access.
- MEMWR to RESPOND after the memory handshake.
- RESPOND to IDLE unconditionally.

Top module: `cache_ctrl_top`

## Requirements
- R1: After reset, every way of every set is invalid. `cpu_ready` and `mem_req_valid` are low, and the first access to any address misses.
- R2: With the defaults (4 words per line, 4 sets, 2 ways), the fields of the byte address are: word offset in bits [3:2], set index in bits [5:4], tag in bits [31:6]. All ways of the set are compared, and at most one way matches.
- R3: A read hit returns the stored word with no memory traffic. `cpu_ready` is high for exactly one cycle per request.
- R4: A read miss fetches the whole line as one memory read per word, at offsets 0 to LINE_WORDS-1 in ascending order. The line is then installed, and the requested word is returned.
- R5: In write-back mode, a write hit changes only the cached line and marks it dirty. Memory is left unchanged.
- R6: In write-back mode, a dirty victim is first written to memory as an ascending burst, then the refill starts. A clean victim is overwritten with no memory write.
- R7: In write-through mode, every write also issues one memory word write carrying the CPU byte strobes. Victims are never written back.
- R8: Under read-allocate, a write miss issues one memory word write and performs no line fetch. The cache is left unchanged, so a later read of that line misses.
- R9: Under write-allocate, a write miss first fills the line from memory, then writes the data into the cache.
- R10: Byte strobe bit b enables data bits [8b+7:8b]. Bytes whose strobe is clear keep their old value.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.
- R12: On a miss, the line is placed in the way given by `victim_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request present; held until cpu_ready |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_be | input | DATA_W/8 | CPU byte strobes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high |
| victim_way | input | WAY_W | Way to replace on a miss, from the replacement block |
| mem_req_valid | output | 1 | Memory word request |
| mem_req_ready | input | 1 | Memory accepts the request, or returns read data |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory write byte strobes |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_req_ready |

## Verification
Two instances receive the same CPU stimulus: a write-back/write-allocate instance and a write-through/read-allocate instance. For each access, the bench counts the memory reads and memory writes it causes. Those counts separate the cases that a simple data comparison cannot tell apart:
- a hit from a miss;
- a clean eviction from a dirty one;
- an allocating write from a non-allocating one.

Full-word writes, partial-strobe writes, conflicting tags in one set, accesses to a second set, and victims pointing at either way are all exercised. After each access, the backing memory is inspected to show when the data actually reaches memory.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRBACK,
        S_REFILL,
        S_MEMWR,
        S_RESPOND
    } cache_state_t;

endpackage

// File: rtl/cache_store.sv
module cache_store #(
    parameter int WAYS       = 2,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 26,
    parameter int WRITE_BACK = 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int OFF_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [OFF_W-1:0]             rd_off,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [OFF_W-1:0]             wr_off,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [BE_W-1:0]              wr_be,
    input  logic                         fill_en,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic                         dirty_set,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    output logic [WAYS-1:0]              way_dirty,
    output logic [WAYS-1:0][DATA_W-1:0]  way_word
);

    logic [SETS-1:0]   valid_q [WAYS];
    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [DATA_W-1:0] data_q  [WAYS][SETS][LINE_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
        end else if (fill_en) begin
            valid_q[wr_way][rd_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[wr_way][rd_set] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) data_q[wr_way][rd_set][wr_off][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    generate
        if (WRITE_BACK != 0) begin : g_dirty
            logic [SETS-1:0] dirty_q [WAYS];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < WAYS; w++) dirty_q[w] <= '0;
                end else if (fill_en) begin
                    dirty_q[wr_way][rd_set] <= 1'b0;
                end else if (dirty_set && wr_en) begin
                    dirty_q[wr_way][rd_set] <= 1'b1;
                end
            end
            always_comb begin
                for (int w = 0; w < WAYS; w++) way_dirty[w] = dirty_q[w][rd_set];
            end
        end else begin : g_nodirty
            assign way_dirty = '0;
        end
    endgenerate

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            way_valid[w] = valid_q[w][rd_set];
            way_tag[w]   = tag_q[w][rd_set];
            way_word[w]  = data_q[w][rd_set][rd_off];
        end
    end

endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 26,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
        end
    endgenerate

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // R2: a tag lives in at most one way of a set
    p_onehot_hit_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

endmodule

// File: rtl/cache_ctrl_top.sv
module cache_ctrl_top
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int WAYS        = 2,
    parameter int SETS        = 4,
    parameter int LINE_WORDS  = 4,
    parameter int WRITE_BACK  = 1,
    parameter int WRITE_ALLOC = 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int OFF_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    localparam int BE_W  = DATA_W / 8,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

    cache_state_t state_q, state_d;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q, rdata_q, rdata_d;
    logic [BE_W-1:0]   req_be_q;
    logic [WAY_W-1:0]  way_q, way_d;
    logic [OFF_W-1:0]  cnt_q, cnt_d;

    logic [OFF_W-1:0]  req_off;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    assign req_off = req_addr_q[2 +: OFF_W];
    assign req_set = req_addr_q[2 + OFF_W +: SET_W];
    assign req_tag = req_addr_q[ADDR_W-1 -: TAG_W];

    logic mem_fire;
    assign mem_fire = mem_req_valid && mem_req_ready;

    logic [OFF_W-1:0]              st_rd_off, st_wr_off;
    logic                          st_wr_en, st_fill, st_dirty;
    logic [WAY_W-1:0]              st_wr_way;
    logic [DATA_W-1:0]             st_wr_data;
    logic [BE_W-1:0]               st_wr_be;
    logic [WAYS-1:0]               way_valid, way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]    way_tag;
    logic [WAYS-1:0][DATA_W-1:0]   way_word;
    logic                          hit;
    logic [WAY_W-1:0]              hit_way;

    cache_store #(
        .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS),
        .DATA_W(DATA_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_set(req_set), .rd_off(st_rd_off),
        .wr_en(st_wr_en), .wr_way(st_wr_way), .wr_off(st_wr_off),
        .wr_data(st_wr_data), .wr_be(st_wr_be),
        .fill_en(st_fill), .fill_tag(req_tag), .dirty_set(st_dirty),
        .way_valid(way_valid), .way_tag(way_tag),
        .way_dirty(way_dirty), .way_word(way_word)
    );

    cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) lookup_i (
        .clk(clk), .rst_n(rst_n),
        .way_valid(way_valid), .way_tag(way_tag), .req_tag(req_tag),
        .hit(hit), .hit_way(hit_way)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            req_be_q    <= '0;
            way_q       <= '0;
            cnt_q       <= '0;
            rdata_q     <= '0;
        end else begin
            if (state_q == S_IDLE && cpu_req_valid) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
                req_be_q    <= cpu_be;
            end
            way_q   <= way_d;
            cnt_q   <= cnt_d;
            rdata_q <= rdata_d;
        end
    end

    assign cpu_rdata = rdata_q;

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        way_d         = way_q;
        cnt_d         = cnt_q;
        rdata_d       = rdata_q;
        cpu_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        mem_be        = '0;
        st_rd_off     = req_off;
        st_wr_en      = 1'b0;
        st_wr_way     = way_q;
        st_wr_off     = req_off;
        st_wr_data    = req_wdata_q;
        st_wr_be      = req_be_q;
        st_fill       = 1'b0;
        st_dirty      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req_valid) state_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (hit) begin
                    if (!req_we_q) begin
                        rdata_d = way_word[hit_way];
                        state_d = S_RESPOND;
                    end else begin
                        st_wr_en  = 1'b1;
                        st_wr_way = hit_way;
                        st_dirty  = (WRITE_BACK != 0);
                        state_d   = (WRITE_BACK != 0) ? S_RESPOND : S_MEMWR;
                    end
                end else if (req_we_q && (WRITE_ALLOC == 0)) begin
                    state_d = S_MEMWR;
                end else begin
                    way_d = victim_way;
                    cnt_d = '0;
                    if ((WRITE_BACK != 0) && way_valid[victim_way] && way_dirty[victim_way])
                        state_d = S_WRBACK;
                    else
                        state_d = S_REFILL;
                end
            end
            S_WRBACK: begin
                st_rd_off     = cnt_q;
                mem_req_valid = 1'b1;
                mem_we        = 1'b1;
                mem_be        = '1;
                mem_addr      = {way_tag[way_q], req_set, cnt_q, 2'b00};
                mem_wdata     = way_word[way_q];
                if (mem_fire) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_OFF) state_d = S_REFILL;
                end
            end
            S_REFILL: begin
                mem_req_valid = 1'b1;
                mem_addr      = {req_tag, req_set, cnt_q, 2'b00};
                if (mem_fire) begin
                    st_wr_en   = 1'b1;
                    st_wr_off  = cnt_q;
                    st_wr_data = mem_rdata;
                    st_wr_be   = '1;
                    cnt_d      = cnt_q + 1'b1;
                    if (cnt_q == LAST_OFF) begin
                        st_fill = 1'b1;
                        state_d = S_LOOKUP;
                    end
                end
            end
            S_MEMWR: begin
                mem_req_valid = 1'b1;
                mem_we        = 1'b1;
                mem_addr      = req_addr_q;
                mem_wdata     = req_wdata_q;
                mem_be        = req_be_q;
                if (mem_fire) state_d = S_RESPOND;
            end
            S_RESPOND: begin
                cpu_ready = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R11: a stalled memory request is held unchanged
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));

    // R4: refill reads advance by one word
    p_refill_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fire && !mem_we && mem_addr[2 +: OFF_W] != LAST_OFF)
        |=> (mem_addr[2 +: OFF_W] == $past(mem_addr[2 +: OFF_W]) + 1'b1));

    // R4: the lookup after the last refill word hits
    p_fill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fire && !mem_we && mem_addr[2 +: OFF_W] == LAST_OFF) |=> hit);

    // R3: completion is a single-cycle pulse
    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

endmodule

// File: tb/cache_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module cache_ctrl_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        wb_valid = 1'b0, wt_valid = 1'b0;
    logic [31:0] c_addr = '0, c_wdata = '0;
    logic        c_we = 1'b0;
    logic [3:0]  c_be = '0;
    logic [0:0]  c_vic = '0;

    logic        wb_ready, wt_ready;
    logic [31:0] wb_rdata, wt_rdata;
    logic        wb_mv, wt_mv, wb_mwe, wt_mwe;
    logic [31:0] wb_maddr, wt_maddr, wb_mwd, wt_mwd, wb_mrd, wt_mrd;
    logic [3:0]  wb_mbe, wt_mbe;
    logic        wb_mrdy, wt_mrdy;

    logic [31:0] wb_mem [1024];
    logic [31:0] wt_mem [1024];
    logic [31:0] ref_mem [1024];
    int cyc = 0;
    int wb_nrd = 0, wb_nwr = 0, wt_nrd = 0, wt_nwr = 0, seq_err = 0;
    logic [1:0] wb_rseq = '0, wb_wseq = '0, wt_rseq = '0;

    logic [31:0] wb_q [$];
    logic [31:0] wt_q [$];

    cache_ctrl_top #(.WRITE_BACK(1), .WRITE_ALLOC(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(wb_valid), .cpu_addr(c_addr),
        .cpu_we(c_we), .cpu_wdata(c_wdata), .cpu_be(c_be), .cpu_ready(wb_ready),
        .cpu_rdata(wb_rdata), .victim_way(c_vic), .mem_req_valid(wb_mv),
        .mem_req_ready(wb_mrdy), .mem_we(wb_mwe), .mem_addr(wb_maddr),
        .mem_wdata(wb_mwd), .mem_be(wb_mbe), .mem_rdata(wb_mrd));

    cache_ctrl_top #(.WRITE_BACK(0), .WRITE_ALLOC(0)) dut_wt_i (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(wt_valid), .cpu_addr(c_addr),
        .cpu_we(c_we), .cpu_wdata(c_wdata), .cpu_be(c_be), .cpu_ready(wt_ready),
        .cpu_rdata(wt_rdata), .victim_way(c_vic), .mem_req_valid(wt_mv),
        .mem_req_ready(wt_mrdy), .mem_we(wt_mwe), .mem_addr(wt_maddr),
        .mem_wdata(wt_mwd), .mem_be(wt_mbe), .mem_rdata(wt_mrd));

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // memory models: write-back instance stalls one cycle in four
    assign wb_mrdy = (cyc[1:0] != 2'b01);
    assign wt_mrdy = 1'b1;
    assign wb_mrd  = wb_mem[wb_maddr[11:2]];
    assign wt_mrd  = wt_mem[wt_maddr[11:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wb_mv && wb_mrdy) begin
            if (wb_mwe) begin
                wb_mem[wb_maddr[11:2]] <= merge(wb_mem[wb_maddr[11:2]], wb_mwd, wb_mbe);
                wb_nwr <= wb_nwr + 1;
                if (wb_maddr[3:2] != wb_wseq) seq_err <= seq_err + 1;
                wb_wseq <= wb_wseq + 1'b1;
            end else begin
                wb_nrd <= wb_nrd + 1;
                if (wb_maddr[3:2] != wb_rseq) seq_err <= seq_err + 1;
                wb_rseq <= wb_rseq + 1'b1;
            end
        end
        if (wt_mv && wt_mrdy) begin
            if (wt_mwe) begin
                wt_mem[wt_maddr[11:2]] <= merge(wt_mem[wt_maddr[11:2]], wt_mwd, wt_mbe);
                wt_nwr <= wt_nwr + 1;
            end else begin
                wt_nrd <= wt_nrd + 1;
                if (wt_maddr[3:2] != wt_rseq) seq_err <= seq_err + 1;
                wt_rseq <= wt_rseq + 1'b1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected read data on each completion
    always @(negedge clk) begin
        if (rst_n && wb_ready) begin
            if (!c_we) begin
                if (wb_q.size() == 0) check("R3 wb unexpected response", 32'h1, 32'h0);
                else check("R3/R4 wb read data", wb_rdata, wb_q.pop_front());
            end
            wb_valid = 1'b0;
        end
        if (rst_n && wt_ready) begin
            if (!c_we) begin
                if (wt_q.size() == 0) check("R3 wt unexpected response", 32'h1, 32'h0);
                else check("R3/R4 wt read data", wt_rdata, wt_q.pop_front());
            end
            wt_valid = 1'b0;
        end
    end

    task automatic step(string req, logic we, logic [31:0] addr, logic [31:0] data,
                        logic [3:0] be, logic vic, int e_wbrd, int e_wbwr, int e_wtrd, int e_wtwr);
        int s_wbrd = wb_nrd, s_wbwr = wb_nwr, s_wtrd = wt_nrd, s_wtwr = wt_nwr;
        @(negedge clk); #1;
        c_addr = addr; c_we = we; c_wdata = data; c_be = be; c_vic = vic;
        if (we) ref_mem[addr[11:2]] = merge(ref_mem[addr[11:2]], data, be);
        else begin
            wb_q.push_back(ref_mem[addr[11:2]]);
            wt_q.push_back(ref_mem[addr[11:2]]);
        end
        wb_valid = 1'b1; wt_valid = 1'b1;
        while (wb_valid || wt_valid) begin @(negedge clk); #1; end
        check({req, " wb mem reads"},  32'(wb_nrd - s_wbrd), 32'(e_wbrd));
        check({req, " wb mem writes"}, 32'(wb_nwr - s_wbwr), 32'(e_wbwr));
        check({req, " wt mem reads"},  32'(wt_nrd - s_wtrd), 32'(e_wtrd));
        check({req, " wt mem writes"}, 32'(wt_nwr - s_wtwr), 32'(e_wtwr));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            wb_mem[i] = 32'hA000_0000 + 32'(i);
            wt_mem[i] = 32'hA000_0000 + 32'(i);
            ref_mem[i] = 32'hA000_0000 + 32'(i);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 wb cpu_ready at reset", {31'd0, wb_ready}, 32'd0);
        check("R1 wb mem_req_valid at reset", {31'd0, wb_mv}, 32'd0);
        check("R1 wt mem_req_valid at reset", {31'd0, wt_mv}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 R4: cold read misses and fetches a line
        step("R1 R4 cold read 0x000", 1'b0, 32'h000, 32'h0, 4'h0, 1'b0, 4, 0, 4, 0);
        // R3: read hit, same line
        step("R3 read hit 0x004", 1'b0, 32'h004, 32'h0, 4'h0, 1'b0, 0, 0, 0, 0);
        // R5 R7: write hit
        step("R5 R7 write hit 0x008", 1'b1, 32'h008, 32'h1234_5678, 4'hF, 1'b0, 0, 0, 0, 1);
        check("R5 wb memory untouched", wb_mem[2], 32'hA000_0002);
        check("R7 wt memory updated", wt_mem[2], 32'h1234_5678);
        step("R3 R5 read back 0x008", 1'b0, 32'h008, 32'h0, 4'h0, 1'b0, 0, 0, 0, 0);
        // R10: partial strobes
        step("R10 byte write 0x008", 1'b1, 32'h008, 32'hFFFF_FFFF, 4'b0010, 1'b0, 0, 0, 0, 1);
        check("R10 wt merged word", wt_mem[2], 32'h1234_FF78);
        step("R10 read merged 0x008", 1'b0, 32'h008, 32'h0, 4'h0, 1'b0, 0, 0, 0, 0);
        // R8 R9: write miss, same set other tag, victim way 1
        step("R8 R9 write miss 0x040", 1'b1, 32'h040, 32'h0000_0055, 4'hF, 1'b1, 4, 0, 0, 1);
        check("R9 wb memory not written", wb_mem[16], 32'hA000_0010);
        check("R8 wt memory written", wt_mem[16], 32'h0000_0055);
        step("R8 R9 read 0x040", 1'b0, 32'h040, 32'h0, 4'h0, 1'b1, 0, 0, 4, 0);
        // R6 R7 R12: evict way 0 (dirty in wb, clean in wt)
        step("R6 R12 dirty evict via 0x080", 1'b0, 32'h080, 32'h0, 4'h0, 1'b0, 4, 4, 4, 0);
        check("R6 wb line written back", wb_mem[2], 32'h1234_FF78);
        check("R6 wb untouched word written back", wb_mem[0], 32'hA000_0000);
        step("R6 R12 evict way 1 via 0x008", 1'b0, 32'h008, 32'h0, 4'h0, 1'b1, 4, 4, 4, 0);
        check("R6 wb write-allocated data written back", wb_mem[16], 32'h0000_0055);
        // R12: 0x080 stayed in way 0
        step("R12 victim placement hit 0x080", 1'b0, 32'h080, 32'h0, 4'h0, 1'b1, 0, 0, 0, 0);
        // R2: other set, clean victims in both
        step("R2 second set 0x014", 1'b0, 32'h014, 32'h0, 4'h0, 1'b0, 4, 0, 4, 0);
        step("R2 second set hit 0x01C", 1'b0, 32'h01C, 32'h0, 4'h0, 1'b0, 0, 0, 0, 0);
        // R4 R6 R11: burst order under stalls
        check("R4 R6 R11 ascending bursts", 32'(seq_err), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog act=hung exp=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule